// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Selector

This block is a purely combinational unit that picks the smaller or the larger of two floating-point operands. Each operand arrives in a 64-bit register image. A precision select tells the unit to read the image as one double-precision value or as a single-precision value held in the low 32 bits. A single-precision value is valid only if all 32 upper bits are ones. The result returns in the same 64-bit image form, together with an invalid-operation flag.

The selection never signals on quiet NaNs. If exactly one operand is a quiet NaN, the other operand is returned. If both operands are NaNs, or if either operand is a signaling NaN, the result is the canonical NaN of the selected precision. A signaling NaN also sets the invalid flag. Zeros of opposite sign compare equal, so the operand order decides which zero comes out. Before any of this, a single-precision operand whose upper half is not all ones is replaced by the canonical single-precision NaN.

The unit sits in an execution pipeline between the operand read and the result write. It has no state and no clock.

Top module: `fp_minmax_sel`

## Requirements
- R1: With `want_max`=0 and both operands ordered, the result is operand A when A < B and operand B otherwise.
- R2: With `want_max`=1 and both operands ordered, the result is operand A when B <= A and operand B otherwise.
- R3: +0 and -0 compare equal. min(-0,+0) returns operand B (+0) and max(+0,-0) returns operand A (+0).
- R4: When exactly one operand is a quiet NaN and neither is signaling, the result is the other operand, unchanged.
- R5: When both operands are NaNs, the result is the canonical NaN: 32'h7FC00000 for single precision and 64'h7FF8000000000000 for double precision.
- R6: When either operand is a signaling NaN, the result is the canonical NaN and `invalid` is 1. A signaling NaN has an all-ones exponent, a nonzero fraction and a fraction MSB of 0.
- R7: `invalid` is 0 whenever neither operand is a signaling NaN, including for quiet NaNs and infinities.
- R8: With `is_double`=0, an operand whose bits [63:32] are not all ones is treated as the canonical single-precision NaN. Such an operand is quiet and never sets `invalid`.
- R9: With `is_double`=0, result bits [63:32] are all ones and the single-precision result is in bits [31:0].
- R10: With `is_double`=1, all 64 bits of each operand form one double-precision value (sign bit 63, exponent bits 62:52, fraction bits 51:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 64 | Operand A register image |
| src_b | input | 64 | Operand B register image |
| is_double | input | 1 | 1 = double precision, 0 = single precision in the low half |
| want_max | input | 1 | 1 = maximum, 0 = minimum |
| result | output | 64 | Selected value in 64-bit register image form |
| invalid | output | 1 | Invalid-operation flag, set by a signaling NaN input |

## Verification
The unit holds no state, so any internal fault appears at `result` and `invalid` as soon as the inputs settle. Possible faults include a wrong classification, a reversed magnitude order for negative values, or a missed box check. The bench sweeps every ordered pair of a graded list of values, in both precisions and both modes. The list covers zeros, denormals, infinities, quiet and signaling NaNs. A comparator that mishandles signed zeros or negative magnitudes returns the wrong operand for specific pairs. A box-check fault makes single-precision operands with a broken box return a number where the other operand was due.

// File: rtl/fpsel_pkg.sv
// Package: shared constants and the operand classification record used by
// the min/max selector. Assumes a 64-bit register image for both precisions.
package fpsel_pkg;
    localparam int REG_W    = 64;
    localparam int SGL_W    = 32;
    localparam int SGL_EXP  = 8;
    localparam int SGL_FRAC = 23;
    localparam int DBL_EXP  = 11;
    localparam int DBL_FRAC = 52;
    localparam int MAG_W    = REG_W - 1;

    localparam logic [SGL_W-1:0] SGL_QNAN = 32'h7FC0_0000;
    localparam logic [REG_W-1:0] DBL_QNAN = 64'h7FF8_0000_0000_0000;
    localparam logic [REG_W-SGL_W-1:0] BOX_ONES = '1;

    // Classification of one operand, widened to the double-precision frame
    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             snan;
        logic             zero;
        logic [MAG_W-1:0] mag;
    } fp_class_t;
endpackage

// File: rtl/fpsel_classify.sv
// Classifier: splits one IEEE-754 encoding of parameterised width into
// sign, NaN, signaling NaN, zero and a zero-extended magnitude.
// Assumes MAG_W >= EXP_W + FRAC_W.
module fpsel_classify #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int MAG_W  = 63
) (
    input  logic [EXP_W+FRAC_W:0] enc,
    output fpsel_pkg::fp_class_t  cls
);
    localparam int BODY_W = EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = enc[BODY_W-1:FRAC_W];
    assign frac_f = enc[FRAC_W-1:0];

    // Derive class flags from the exponent and fraction fields
    always_comb begin
        cls.sign = enc[BODY_W];
        cls.nan  = (&exp_f) && (|frac_f);
        cls.snan = (&exp_f) && (|frac_f) && !frac_f[FRAC_W-1];
        cls.zero = !(|enc[BODY_W-1:0]);
        cls.mag  = {{(MAG_W-BODY_W){1'b0}}, enc[BODY_W-1:0]};
    end
endmodule

// File: rtl/fpsel_operand.sv
// Operand front end: checks the single-precision box, substitutes the
// canonical single NaN when the box is broken, and classifies the value in
// the selected precision. Both precisions are classified by generated
// instances and the selected one is passed on.
module fpsel_operand
    import fpsel_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0] raw,
    input  logic         is_double,
    output logic [W-1:0] value,
    output fp_class_t    cls
);
    localparam int HALF = W / 2;

    logic      box_ok;
    fp_class_t cls_by_fmt [2];

    // Replace badly boxed single-precision operands with the canonical NaN
    always_comb begin
        box_ok = &raw[W-1:HALF];
        if (is_double || box_ok) value = raw;
        else                     value = {BOX_ONES, SGL_QNAN};
    end

    for (genvar f = 0; f < 2; f++) begin : g_fmt
        if (f == 0) begin : g_sgl
            fpsel_classify #(.EXP_W(SGL_EXP), .FRAC_W(SGL_FRAC), .MAG_W(MAG_W)) u_cls (
                .enc (value[HALF-1:0]),
                .cls (cls_by_fmt[f])
            );
        end else begin : g_dbl
            fpsel_classify #(.EXP_W(DBL_EXP), .FRAC_W(DBL_FRAC), .MAG_W(MAG_W)) u_cls (
                .enc (value),
                .cls (cls_by_fmt[f])
            );
        end
    end

    // Pass on the classification of the selected precision
    always_comb cls = cls_by_fmt[is_double];
endmodule

// File: rtl/fpsel_compare.sv
// Quiet comparator: orders two classified operands. NaNs make the pair
// unordered. Zeros of either sign are equal. Only signaling NaNs raise invalid.
module fpsel_compare
    import fpsel_pkg::*;
(
    input  fp_class_t ca,
    input  fp_class_t cb,
    output logic      a_lt_b,
    output logic      a_eq_b,
    output logic      unordered,
    output logic      invalid
);
    // Order by sign first, then by magnitude reversed for negatives
    always_comb begin
        unordered = ca.nan || cb.nan;
        invalid   = ca.snan || cb.snan;
        a_lt_b    = 1'b0;
        a_eq_b    = 1'b0;
        if (!unordered) begin
            if (ca.zero && cb.zero) begin
                a_eq_b = 1'b1;
            end else if (ca.sign != cb.sign) begin
                a_lt_b = ca.sign;
            end else begin
                a_eq_b = (ca.mag == cb.mag);
                a_lt_b = ca.sign ? (ca.mag > cb.mag) : (ca.mag < cb.mag);
            end
        end
    end

    // R3: two zeros of any sign must compare equal and never less-than
    always_comb begin
        if (!ca.nan && !cb.nan && ca.zero && cb.zero)
            assert_zero_equal_R3: assert (a_eq_b && !a_lt_b)
                else $error("zero pair ordered incorrectly");
    end
endmodule

// File: rtl/fpsel_pick.sv
// Result selector: takes the comparison outcome and chooses A, B or the
// canonical NaN, then boxes a single-precision result into 64 bits.
module fpsel_pick
    import fpsel_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0] val_a,
    input  logic [W-1:0] val_b,
    input  logic         a_nan,
    input  logic         b_nan,
    input  logic         a_lt_b,
    input  logic         unordered,
    input  logic         invalid,
    input  logic         want_max,
    input  logic         is_double,
    output logic [W-1:0] result
);
    localparam int HALF = W / 2;

    logic         take_a;
    logic         canon;
    logic [W-1:0] chosen;

    // Decide which operand wins, or whether the canonical NaN is forced
    always_comb begin
        if (want_max) take_a = (!unordered && !a_lt_b) || b_nan;
        else          take_a = a_lt_b || b_nan;
        canon  = (a_nan && b_nan) || invalid;
        chosen = take_a ? val_a : val_b;
    end

    // Format the output in the selected precision
    always_comb begin
        if (is_double) result = canon ? DBL_QNAN : chosen;
        else           result = {BOX_ONES, canon ? SGL_QNAN : chosen[HALF-1:0]};
    end
endmodule

// File: rtl/fp_minmax_sel.sv
// Top: minimum/maximum of two floating-point operands in 64-bit register
// image form, single or double precision. Purely combinational, no reset.
// Assumes the inputs are stable while the result is consumed.
module fp_minmax_sel
    import fpsel_pkg::*;
(
    input  logic [63:0] src_a,
    input  logic [63:0] src_b,
    input  logic        is_double,
    input  logic        want_max,
    output logic [63:0] result,
    output logic        invalid
);
    logic [REG_W-1:0] val_a, val_b;
    fp_class_t        cls_a, cls_b;
    logic             a_lt_b, a_eq_b, unordered;

    fpsel_operand #(.W(REG_W)) u_opa (
        .raw (src_a), .is_double (is_double), .value (val_a), .cls (cls_a)
    );
    fpsel_operand #(.W(REG_W)) u_opb (
        .raw (src_b), .is_double (is_double), .value (val_b), .cls (cls_b)
    );

    fpsel_compare u_cmp (
        .ca (cls_a), .cb (cls_b),
        .a_lt_b (a_lt_b), .a_eq_b (a_eq_b),
        .unordered (unordered), .invalid (invalid)
    );

    fpsel_pick #(.W(REG_W)) u_pick (
        .val_a (val_a), .val_b (val_b),
        .a_nan (cls_a.nan), .b_nan (cls_b.nan),
        .a_lt_b (a_lt_b), .unordered (unordered), .invalid (invalid),
        .want_max (want_max), .is_double (is_double),
        .result (result)
    );

    // Guard the output against the classification of the operands
    always_comb begin
        // R6: a signaling input must always give the canonical NaN
        if (cls_a.snan || cls_b.snan)
            assert_snan_canon_R6: assert (invalid &&
                (is_double ? (result == DBL_QNAN) : (result[31:0] == SGL_QNAN)))
                else $error("signaling input did not force canonical NaN");
        // R9: a single-precision result is always boxed
        if (!is_double)
            assert_boxed_result_R9: assert (&result[63:32])
                else $error("single result not boxed");
        // R4: a lone quiet NaN yields the other operand
        if ((cls_a.nan != cls_b.nan) && !invalid)
            assert_lone_nan_R4: assert (is_double ?
                (result == (cls_a.nan ? val_b : val_a)) :
                (result[31:0] == (cls_a.nan ? val_b[31:0] : val_a[31:0])))
                else $error("lone NaN did not pass other operand");
        // R7: invalid requires a signaling operand
        assert_inv_cause_R7: assert (!invalid || cls_a.snan || cls_b.snan)
            else $error("invalid without signaling operand");
    end
endmodule

// File: tb/fp_minmax_sel_bench.sv
module fp_minmax_sel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;
    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic [63:0] src_a, src_b, result;
    logic        is_double, want_max, invalid;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    logic [31:0] sv [NV];
    logic [63:0] dv [NV];
    int          rk [NV];
    int          kind [NV];   // 0 number, 1 quiet NaN, 2 signaling NaN

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_minmax_sel u_fp_minmax_sel (
        .src_a (src_a), .src_b (src_b), .is_double (is_double),
        .want_max (want_max), .result (result), .invalid (invalid)
    );

    task automatic check(input logic [63:0] got_r, input logic got_i,
                         input logic [63:0] exp_r, input logic exp_i,
                         input string tag);
        total++;
        if (got_r !== exp_r || got_i !== exp_i) begin
            bad++;
            $display("FAIL %s: a=%h b=%h dbl=%0d max=%0d got %h/%0d expected %h/%0d",
                     tag, src_a, src_b, is_double, want_max, got_r, got_i, exp_r, exp_i);
        end
    endtask

    task automatic apply(input logic [63:0] a, input logic [63:0] b,
                         input logic dbl, input logic mx);
        @(posedge clk);
        src_a = a; src_b = b; is_double = dbl; want_max = mx;
        @(negedge clk);
    endtask

    initial begin
        sv[0]=32'hFF80_0000; dv[0]=64'hFFF0_0000_0000_0000; rk[0]=0; kind[0]=0;
        sv[1]=32'hC000_0000; dv[1]=64'hC000_0000_0000_0000; rk[1]=1; kind[1]=0;
        sv[2]=32'hBF80_0000; dv[2]=64'hBFF0_0000_0000_0000; rk[2]=2; kind[2]=0;
        sv[3]=32'h8000_0001; dv[3]=64'h8000_0000_0000_0001; rk[3]=3; kind[3]=0;
        sv[4]=32'h8000_0000; dv[4]=64'h8000_0000_0000_0000; rk[4]=4; kind[4]=0;
        sv[5]=32'h0000_0000; dv[5]=64'h0000_0000_0000_0000; rk[5]=4; kind[5]=0;
        sv[6]=32'h0000_0001; dv[6]=64'h0000_0000_0000_0001; rk[6]=5; kind[6]=0;
        sv[7]=32'h3F80_0000; dv[7]=64'h3FF0_0000_0000_0000; rk[7]=6; kind[7]=0;
        sv[8]=32'h3FC0_0000; dv[8]=64'h3FF8_0000_0000_0000; rk[8]=7; kind[8]=0;
        sv[9]=32'h7F80_0000; dv[9]=64'h7FF0_0000_0000_0000; rk[9]=8; kind[9]=0;
        sv[10]=32'h7FC0_0001; dv[10]=64'h7FF8_0000_0000_0001; rk[10]=0; kind[10]=1;
        sv[11]=32'h7F80_0001; dv[11]=64'h7FF0_0000_0000_0001; rk[11]=0; kind[11]=2;
        sv[12]=32'hFFC0_0000; dv[12]=64'hFFF8_0000_0000_0000; rk[12]=0; kind[12]=1;

        src_a = '0; src_b = '0; is_double = 1'b1; want_max = 1'b0;
        @(negedge clk);
        // Idle state: both zero inputs give zero, no invalid (R1)
        check(result, invalid, 64'h0, 1'b0, "R1 idle");

        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < NV; i++) begin
                for (int j = 0; j < NV; j++) begin
                    for (int m = 0; m < 2; m++) begin
                        logic [63:0] ea, eb, er, canon;
                        logic        ei, take_a;
                        string       tag;
                        ea = (p == 1) ? dv[i] : {32'hFFFF_FFFF, sv[i]};
                        eb = (p == 1) ? dv[j] : {32'hFFFF_FFFF, sv[j]};
                        canon = (p == 1) ? 64'h7FF8_0000_0000_0000 : 64'hFFFF_FFFF_7FC0_0000;
                        ei = (kind[i] == 2) || (kind[j] == 2);
                        if (ei) begin
                            er = canon; tag = "R6";
                        end else if (kind[i] != 0 && kind[j] != 0) begin
                            er = canon; tag = "R5";
                        end else if (kind[i] != 0) begin
                            er = eb; tag = "R4";
                        end else if (kind[j] != 0) begin
                            er = ea; tag = "R4";
                        end else begin
                            if (m == 1) take_a = (rk[j] <= rk[i]);
                            else        take_a = (rk[i] < rk[j]);
                            er = take_a ? ea : eb;
                            if (rk[i] == 4 && rk[j] == 4) tag = "R3";
                            else tag = (m == 1) ? "R2" : "R1";
                        end
                        if (!ei) tag = {tag, " R7"};
                        tag = {tag, (p == 1) ? " R10" : " R9"};
                        apply(ea, eb, p[0], m[0]);
                        check(result, invalid, er, ei, tag);
                    end
                end
            end
        end

        // R3: explicit signed-zero cases
        apply(64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_0000_0000, 1'b0, 1'b0);
        check(result, invalid, 64'hFFFF_FFFF_0000_0000, 1'b0, "R3 min(-0,+0)");
        apply(64'h0, 64'h8000_0000_0000_0000, 1'b1, 1'b1);
        check(result, invalid, 64'h0, 1'b0, "R3 max(+0,-0)");

        // R8: broken box on A becomes quiet NaN, B returned
        apply(64'h0000_0000_3F80_0000, 64'hFFFF_FFFF_BF80_0000, 1'b0, 1'b0);
        check(result, invalid, 64'hFFFF_FFFF_BF80_0000, 1'b0, "R8 broken A");
        // R8: broken box carrying a signaling pattern raises nothing
        apply(64'hFFFF_FFFE_7F80_0001, 64'hFFFF_FFFF_3F80_0000, 1'b0, 1'b1);
        check(result, invalid, 64'hFFFF_FFFF_3F80_0000, 1'b0, "R8 broken sNaN A");
        // R8: both broken gives canonical single NaN
        apply(64'h1234_5678_3F80_0000, 64'h0000_0001_4000_0000, 1'b0, 1'b1);
        check(result, invalid, 64'hFFFF_FFFF_7FC0_0000, 1'b0, "R8 both broken");
        // R8: broken B, A returned
        apply(64'hFFFF_FFFF_C000_0000, 64'h7FFF_FFFF_C000_0000, 1'b0, 1'b1);
        check(result, invalid, 64'hFFFF_FFFF_C000_0000, 1'b0, "R8 broken B");
        // R10: double mode uses full width, no box rule
        apply(64'h0000_0000_3F80_0000, 64'h3FF0_0000_0000_0000, 1'b1, 1'b1);
        check(result, invalid, 64'h3FF0_0000_0000_0000, 1'b0, "R10 full width");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule